// File: doc/BRIEF.md
# Locking Priority Arbiter for a Shared DMA Master Port

This block decides which of several DMA channels owns a single shared master bus port. Every channel presents a request line, a priority value, a lock-enable bit and a two-bit lock scope. The arbiter registers a one-hot grant. Among requesting channels, the one with the largest priority value wins. When several requesters share the largest value, the lowest channel index wins. Without a lock, ownership is decided again on every clock, so a higher-priority request takes the port on the next cycle.

A channel that wins while its lock bit is set keeps the port for the whole of its lock scope. While it holds the port, it ignores every other request, whatever that request's priority. Scope 01 ends at the next block-end or transfer-end pulse from the owner. Scope 00 ends only at a transfer-end pulse. Scopes 10 and 11 are treated as no lock. The lock also ends if the owner drops its request. The single grant covers the read-address, write-address and write-data paths of the port together.

The block does not check whether locking suits the transfer type, and it does not check whether priority values are legal. Both are left to the software that programs the channels.

Top module: `dma_lock_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `gnt` is all zeros.
- R2: At most one bit of `gnt` is set. A set bit always belongs to a channel whose `req` was high in the previous cycle.
- R3: Priority of channel i is `prio[i*PW +: PW]`, and a larger value ranks higher. The grant goes to the requesting channel with the largest value and appears one clock after the requests are sampled.
- R4: When requesters tie on the largest priority, the one with the lowest index is granted.
- R5: An unlocked owner loses the port in the next cycle when a higher-ranked channel requests.
- R6: The lock scope of channel i is `lock_lvl[2*i+1:2*i]`. A winner with `lock_en` set and scope 01 keeps `gnt` against all other requests until a `blk_end` or `xfer_end` pulse. The grant is decided afresh in the cycle after that pulse.
- R7: A winner with `lock_en` set and scope 00 ignores `blk_end` and keeps the port until an `xfer_end` pulse.
- R8: Scope values 10 and 11 behave as no lock, even when `lock_en` is set.
- R9: A locked owner that drops `req` releases the port. The next grant is decided in the following cycle.
- R10: With no requests, `gnt` is all zeros one cycle later.
- R11: `blk_end` and `xfer_end` pulses have no effect on the grant while the owner is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NCH | Per-channel request |
| prio | input | NCH*PW | Packed per-channel priority, PW bits each |
| lock_en | input | NCH | Per-channel lock enable |
| lock_lvl | input | 2*NCH | Packed per-channel lock scope, 2 bits each |
| blk_end | input | 1 | Block-end pulse from the owning channel |
| xfer_end | input | 1 | Transfer-end pulse from the owning channel |
| gnt | output | NCH | One-hot grant, registered |

## Verification
The hardest situation to reach is an owner that is held by a transfer-scope lock while a higher-priority channel is waiting and a `blk_end` pulse arrives. The grant must stay put through that pulse and move only on `xfer_end`.

Directed sequences reach this state on purpose. A low-priority locking channel is allowed to win alone. A top-priority rival is then raised, and the two end pulses follow in turn.

A long random phase follows, with sparse end pulses and random lock settings. It mixes released, re-taken and dropped locks, and a behavioural model checks the grant on every cycle.

// File: rtl/dma_lock_arbiter.sv
module dma_lock_arbiter #(
  parameter int NCH = 4,
  parameter int PW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req,
  input  logic [NCH*PW-1:0] prio,
  input  logic [NCH-1:0]    lock_en,
  input  logic [2*NCH-1:0]  lock_lvl,
  input  logic              blk_end,
  input  logic              xfer_end,
  output logic [NCH-1:0]    gnt
);

  logic [NCH-1:0] gnt_q, win;
  logic           locked_q, blk_scope_q;
  logic           owner_req, release_ev, hold, win_locks, win_blk;

  assign owner_req  = |(req & gnt_q);
  assign release_ev = xfer_end | (blk_scope_q & blk_end);
  assign hold       = locked_q & owner_req & ~release_ev;

  always_comb begin
    logic [PW-1:0] best_p;
    logic          found;
    win       = '0;
    best_p    = '0;
    found     = 1'b0;
    win_locks = 1'b0;
    win_blk   = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && (!found || prio[i*PW +: PW] > best_p)) begin
        win       = '0;
        win[i]    = 1'b1;
        best_p    = prio[i*PW +: PW];
        found     = 1'b1;
        win_locks = lock_en[i] & ~lock_lvl[2*i+1];
        win_blk   = lock_lvl[2*i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q       <= '0;
      locked_q    <= 1'b0;
      blk_scope_q <= 1'b0;
    end else if (!hold) begin
      gnt_q       <= win;
      locked_q    <= win_locks;
      blk_scope_q <= win_blk;
    end
  end

  assign gnt = gnt_q;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  assert_grant_had_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0) |-> (($past(req) & gnt_q) != '0));

  assert_idle_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (gnt_q == '0));

  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && owner_req && !xfer_end && !blk_end) |=> $stable(gnt_q));

  assert_xfer_scope_ignores_blk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !blk_scope_q && owner_req && blk_end && !xfer_end) |=> $stable(gnt_q));

endmodule

// File: tb/dma_lock_arbiter_test.sv
module dma_lock_arbiter_test;
  localparam int NCH = 4;
  localparam int PW  = 2;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0]    req = '0, lock_en = '0, gnt;
  logic [NCH*PW-1:0] prio = '0;
  logic [2*NCH-1:0]  lock_lvl = '0;
  logic              blk_end = 0, xfer_end = 0;

  int    checks = 0, fails = 0;
  string tag = "R1";
  bit    done = 0;

  int own = -1;
  bit mlock = 0, mblk = 0;

  always #2 clk = ~clk;

  dma_lock_arbiter #(.NCH(NCH), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .lock_en(lock_en),
    .lock_lvl(lock_lvl), .blk_end(blk_end), .xfer_end(xfer_end), .gnt(gnt));

  always @(posedge clk) begin
    if (!rst_n) begin
      own = -1; mlock = 0; mblk = 0;
    end else begin
      bit keep;
      keep = mlock && own >= 0 && req[own] && !(xfer_end || (mblk && blk_end));
      if (!keep) begin
        int best;
        best = -1;
        for (int i = 0; i < NCH; i++)
          if (req[i] && (best < 0 || prio[i*PW +: PW] > prio[best*PW +: PW])) best = i;
        own = best;
        mlock = 0;
        if (best >= 0 && lock_en[best] && !lock_lvl[2*best+1]) begin
          mlock = 1;
          mblk  = lock_lvl[2*best];
        end
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      logic [NCH-1:0] exp;
      @(negedge clk);
      exp = (own >= 0) ? (NCH'(1) << own) : '0;
      checks++;
      if (gnt !== exp) begin
        fails++;
        $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
      end
    end
  endtask

  task automatic setch(int ch, bit r, int p, bit le, int lv);
    req[ch] = r;
    prio[ch*PW +: PW] = PW'(p);
    lock_en[ch] = le;
    lock_lvl[2*ch +: 2] = 2'(lv);
  endtask

  task automatic clear_all();
    req = '0; prio = '0; lock_en = '0; lock_lvl = '0; blk_end = 0; xfer_end = 0;
  endtask

  task automatic pulse(bit b, bit x);
    blk_end = b; xfer_end = x;
    cyc();
    blk_end = 0; xfer_end = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tag = "R1 reset"; cyc(3);
    rst_n = 1; cyc(1);

    tag = "R10 idle"; cyc(3);

    tag = "R3 highest priority";
    setch(0, 1, 1, 0, 0); setch(1, 1, 2, 0, 0); setch(2, 1, 3, 0, 0); cyc(3);
    clear_all(); cyc(2);

    tag = "R4 tie lowest index";
    setch(1, 1, 2, 0, 0); setch(3, 1, 2, 0, 0); cyc(3);
    clear_all(); cyc(2);

    tag = "R5 preempt unlocked";
    setch(0, 1, 0, 0, 0); cyc(2);
    setch(3, 1, 3, 0, 0); cyc(3);
    clear_all(); cyc(2);

    tag = "R6 block lock";
    setch(0, 1, 0, 1, 1); cyc(2);
    setch(3, 1, 3, 0, 0); cyc(4);
    pulse(1, 0); cyc(3);
    clear_all(); cyc(2);

    tag = "R6 block lock ends on xfer_end";
    setch(1, 1, 0, 1, 1); cyc(2);
    setch(2, 1, 3, 0, 0); cyc(2);
    pulse(0, 1); cyc(2);
    clear_all(); cyc(2);

    tag = "R7 transfer lock";
    setch(1, 1, 1, 1, 0); cyc(2);
    setch(3, 1, 3, 0, 0); cyc(2);
    pulse(1, 0); cyc(3);
    pulse(1, 0); cyc(2);
    pulse(0, 1); cyc(3);
    clear_all(); cyc(2);

    tag = "R8 reserved scope";
    setch(0, 1, 0, 1, 2); cyc(2);
    setch(3, 1, 3, 0, 0); cyc(3);
    clear_all(); cyc(1);
    setch(0, 1, 0, 1, 3); cyc(2);
    setch(2, 1, 2, 0, 0); cyc(3);
    clear_all(); cyc(2);

    tag = "R9 locked owner drops request";
    setch(0, 1, 0, 1, 0); cyc(2);
    setch(3, 1, 3, 0, 0); cyc(2);
    req[0] = 0; cyc(3);
    clear_all(); cyc(2);

    tag = "R11 pulses while unlocked";
    setch(1, 1, 2, 0, 0); cyc(2);
    pulse(1, 0); pulse(0, 1); pulse(1, 1); cyc(2);
    clear_all(); cyc(2);

    tag = "R2 random";
    for (int n = 0; n < 4000; n++) begin
      req      = NCH'($urandom);
      prio     = (NCH*PW)'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        lock_en  = NCH'($urandom);
        lock_lvl = (2*NCH)'($urandom);
      end
      blk_end  = ($urandom_range(0, 5) == 0);
      xfer_end = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 3) != 0) req = req | gnt;
      cyc();
    end
    clear_all(); cyc(2);

    tag = "R1 reset mid-lock";
    setch(0, 1, 0, 1, 0); cyc(2);
    rst_n = 0; cyc(2);
    rst_n = 1; clear_all(); cyc(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule